// File: doc/BRIEF.md
# Programmable Countdown Timer Channel

This block is one down-counting timer channel. A register front end loads a count value together with a four-bit configuration word. Three configuration bits pick one of six waveform behaviours. The remaining bit picks either plain binary counting or four-digit decimal (BCD) counting. The channel counts on clock cycles where the `tick` enable is high. A `gate` input suspends, restarts or triggers the count, depending on the mode. A single output line then carries one of several waveforms:

- a terminal-count flag,
- a retriggerable one-shot pulse,
- a periodic single-cycle pulse,
- a square wave,
- a single strobe started by software or by the gate.

The live count is always visible on `count` so that a front end can snapshot it. Several identical channels are normally placed side by side, for example one as a periodic interrupt source and one as a tone generator. Bus decoding and byte sequencing belong to the front end and are not part of this block.

A load always restarts the channel and takes precedence over every other event in the same cycle. All references to "ticks" below mean rising clock edges at which `tick` is high. The `gate` input is sampled on those ticks.

Top module: `timer_channel`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out` is 1 and `count` is 0. No counting takes place until the first load.
- R2: Mode 0 (`load_cfg[3:1]` = 0) drives `out` low on the load. `out` then stays low for exactly N ticks (N = load value). It rises on the tick that brings the count to zero and stays high until the next load.
- R3: Mode 1 (code 1) keeps `out` high after a load until `gate` is seen high on a tick after being low on the previous tick. From that tick on, `out` is low for exactly N ticks and then returns high.
- R4: Mode 2 (code 2) repeats with a period of N ticks. In each period `out` is low for exactly one tick. The first high run after the load lasts N ticks counting the load cycle, and later high runs last N-1 ticks.
- R5: Mode 3 (code 3) produces a square wave. `out` is high for ceil(N/2) ticks and low for floor(N/2) ticks, for both even and odd N ≥ 2, in binary and in BCD.
- R6: Mode 4 (code 4) starts counting on the load. `out` goes low for exactly one tick when the count reaches zero (N ticks after the load), and no further pulse follows until the next load.
- R7: Mode 5 (code 5) does not count until a rising gate is seen on a tick. N ticks later it pulses `out` low for exactly one tick, only once per trigger.
- R8: In modes 0 and 4, a low `gate` freezes `count` and the output state. Counting resumes where it stopped once `gate` is high again.
- R9: In modes 2 and 3, a low `gate` forces `out` high on the next cycle and reloads the count to N. When the gate returns high, a full first period starts.
- R10: With `load_cfg[0]` = 1, each nibble of `count` is a decimal digit. A decrement borrows from digit to digit, so that 0x1000 becomes 0x0999 and 0x0010 becomes 0x0009.
- R11: A load value of 0 stands for 65536 ticks in binary and 10000 ticks in BCD.
- R12: Mode codes 6 and 7 behave exactly as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable; one count step per cycle where high |
| gate | input | 1 | Gate / trigger input, sampled on ticks |
| load | input | 1 | One-cycle strobe: capture `load_cfg` and `load_val`, restart the channel |
| load_cfg | input | 4 | [3:1] mode code, [0] BCD select |
| load_val | input | 16 | Initial / reload count N |
| out | output | 1 | Channel output waveform |
| count | output | 16 | Live counter value |

## Verification
Each mode is run with a small count, and the lengths of successive high and low runs of `out` are measured. This separates the first period from later periods and even N from odd N, which is where off-by-one reload and half-period faults show up. The gate is dropped part-way through a count, which distinguishes freezing (modes 0 and 4) from forced-high restart (modes 2 and 3). In the triggered modes, the gate is held low after the load, which shows that nothing starts without a rising edge. BCD loads of 0x1000, 0x0010 and zero, together with a binary zero load, expose digit-borrow and full-range terminal faults that small binary counts cannot reveal.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam int CNT_W  = 16;
    localparam int DIGITS = CNT_W / 4;

    typedef enum logic [2:0] {
        M_TERM     = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } tmode_e;

    typedef struct packed {
        tmode_e             mode;
        logic               bcd;
        logic [CNT_W-1:0]   reload;
    } cfg_t;

    // Codes 6 and 7 fold onto the rate and square modes.
    function automatic tmode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd6:    return M_RATE;
            3'd7:    return M_SQUARE;
            default: return tmode_e'(code);
        endcase
    endfunction

    // One count step, binary wrap or per-digit decimal borrow.
    function automatic logic [CNT_W-1:0] count_dec(input logic [CNT_W-1:0] v,
                                                    input logic bcd);
        logic [CNT_W-1:0] r;
        logic             borrow;
        r      = v;
        borrow = 1'b1;
        if (!bcd) begin
            r = v - CNT_W'(1);
        end else begin
            for (int d = 0; d < DIGITS; d++) begin
                if (borrow) begin
                    if (v[d*4 +: 4] == 4'd0) begin
                        r[d*4 +: 4] = 4'd9;
                    end else begin
                        r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
                        borrow      = 1'b0;
                    end
                end
            end
        end
        return r;
    endfunction

    function automatic logic digits_ok(input logic [CNT_W-1:0] v);
        for (int d = 0; d < DIGITS; d++) begin
            if (v[d*4 +: 4] > 4'd9) return 1'b0;
        end
        return 1'b1;
    endfunction

endpackage

// File: rtl/tc_cfg.sv
module tc_cfg
    import tc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  tmode_e           ld_mode,
    input  logic             ld_bcd,
    input  logic [CNT_W-1:0] ld_val,
    output cfg_t             cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{mode: M_TERM, bcd: 1'b0, reload: '0};
        end else if (load) begin
            cfg_q <= '{mode: ld_mode, bcd: ld_bcd, reload: ld_val};
        end
    end

endmodule

// File: rtl/tc_trigger.sv
module tc_trigger (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic gate,
    output logic trig
);

    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
        end else if (tick) begin
            gate_q <= gate;
        end
    end

    assign trig = tick && gate && !gate_q;

endmodule

// File: rtl/tc_core.sv
module tc_core
    import tc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             gate,
    input  logic             trig,
    input  logic             load,
    input  tmode_e           ld_mode,
    input  logic [CNT_W-1:0] ld_val,
    input  cfg_t             cfg,
    output logic             loaded,
    output logic             out_q,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic             live;
    logic [CNT_W-1:0] dec1;
    logic [CNT_W-1:0] dec2;
    logic [CNT_W-1:0] reload_even;

    always_comb begin
        dec1        = count_dec(cnt, cfg.bcd);
        dec2        = count_dec(dec1, cfg.bcd);
        reload_even = cfg.reload & ~ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            out_q  <= 1'b1;
            live   <= 1'b0;
            loaded <= 1'b0;
        end else if (load) begin
            cnt    <= ld_val;
            loaded <= 1'b1;
            live   <= !(ld_mode == M_ONESHOT || ld_mode == M_HWSTROBE);
            out_q  <= (ld_mode != M_TERM);
        end else if (loaded) begin
            case (cfg.mode)
                M_TERM: begin
                    if (tick && gate && live) begin
                        cnt <= dec1;
                        if (cnt == ONE) begin
                            out_q <= 1'b1;
                            live  <= 1'b0;
                        end
                    end
                end
                M_ONESHOT: begin
                    if (tick) begin
                        if (trig) begin
                            cnt   <= cfg.reload;
                            out_q <= 1'b0;
                            live  <= 1'b1;
                        end else if (live) begin
                            cnt <= dec1;
                            if (cnt == ONE) begin
                                out_q <= 1'b1;
                                live  <= 1'b0;
                            end
                        end
                    end
                end
                M_HWSTROBE: begin
                    if (tick) begin
                        out_q <= 1'b1;
                        if (trig) begin
                            cnt  <= cfg.reload;
                            live <= 1'b1;
                        end else if (live) begin
                            cnt <= dec1;
                            if (cnt == ONE) begin
                                out_q <= 1'b0;
                                live  <= 1'b0;
                            end
                        end
                    end
                end
                M_SWSTROBE: begin
                    if (tick) begin
                        out_q <= 1'b1;
                        if (gate && live) begin
                            cnt <= dec1;
                            if (cnt == ONE) begin
                                out_q <= 1'b0;
                                live  <= 1'b0;
                            end
                        end
                    end
                end
                M_RATE: begin
                    if (!gate) begin
                        out_q <= 1'b1;
                        cnt   <= cfg.reload;
                    end else if (tick) begin
                        if (cnt == ONE) begin
                            cnt   <= cfg.reload;
                            out_q <= 1'b0;
                        end else begin
                            cnt   <= dec1;
                            out_q <= 1'b1;
                        end
                    end
                end
                M_SQUARE: begin
                    if (!gate) begin
                        out_q <= 1'b1;
                        cnt   <= cfg.reload;
                    end else if (tick) begin
                        if (cnt == TWO) begin
                            out_q <= !out_q;
                            cnt   <= out_q ? reload_even : cfg.reload;
                        end else if (out_q && cnt[0]) begin
                            cnt <= dec1;
                        end else begin
                            cnt <= dec2;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import tc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             gate,
    input  logic             load,
    input  logic [3:0]       load_cfg,
    input  logic [CNT_W-1:0] load_val,
    output logic             out,
    output logic [CNT_W-1:0] count
);

    tmode_e ld_mode;
    cfg_t   cfg_q;
    logic   trig;
    logic   loaded;

    assign ld_mode = decode_mode(load_cfg[3:1]);

    tc_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .ld_mode (ld_mode),
        .ld_bcd  (load_cfg[0]),
        .ld_val  (load_val),
        .cfg_q   (cfg_q)
    );

    tc_trigger u_trig (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .gate (gate),
        .trig (trig)
    );

    tc_core u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .gate    (gate),
        .trig    (trig),
        .load    (load),
        .ld_mode (ld_mode),
        .ld_val  (load_val),
        .cfg     (cfg_q),
        .loaded  (loaded),
        .out_q   (out),
        .cnt     (count)
    );

endmodule

// File: rtl/tc_checker.sv
module tc_checker
    import tc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             load,
    input logic             tick,
    input logic             gate,
    input logic             out,
    input logic [CNT_W-1:0] count,
    input tmode_e           mode,
    input logic             bcd,
    input logic             loaded
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (out && count == '0));

    // R2
    term_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (loaded && mode == M_TERM && out && !load) |=> out);

    // R3
    oneshot_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (loaded && mode == M_ONESHOT && out && !load && !(tick && gate)) |=> out);

    // R6 R7
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        (loaded && (mode == M_SWSTROBE || mode == M_HWSTROBE) && !out && tick && !load)
        |=> out);

    // R8
    suspend_chk: assert property (@(posedge clk) disable iff (rst)
        (loaded && (mode == M_TERM || mode == M_SWSTROBE) && !gate && !load)
        |=> $stable(count));

    // R9
    gate_force_chk: assert property (@(posedge clk) disable iff (rst)
        (loaded && (mode == M_RATE || mode == M_SQUARE) && !gate && !load) |=> out);

    // R10
    bcd_digit_chk: assert property (@(posedge clk) disable iff (rst)
        (loaded && bcd && digits_ok(count) && !load) |=> digits_ok(count));

endmodule

bind timer_channel tc_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .tick   (tick),
    .gate   (gate),
    .out    (out),
    .count  (count),
    .mode   (cfg_q.mode),
    .bcd    (cfg_q.bcd),
    .loaded (loaded)
);

// File: tb/sim_timer_channel.sv
module sim_timer_channel;

    localparam int CLK_PERIOD = 10;
    localparam int RUN_LIMIT  = 70000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        gate = 1'b1;
    logic        load = 1'b0;
    logic [3:0]  load_cfg = '0;
    logic [15:0] load_val = '0;
    logic        out;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_channel u0 (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .gate     (gate),
        .load     (load),
        .load_cfg (load_cfg),
        .load_val (load_val),
        .out      (out),
        .count    (count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [2:0] code, input logic bcd, input logic [15:0] val);
        @(negedge clk);
        load     = 1'b1;
        load_cfg = {code, bcd};
        load_val = val;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (out === lvl && n < RUN_LIMIT) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic stays_high(input string req, input int cycles);
        int highs;
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            if (out === 1'b1) highs++;
            @(negedge clk);
        end
        chk(req, highs, cycles);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 out in reset", int'(out), 1);
        chk("R1 count in reset", int'(count), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 count idle after reset", int'(count), 0);
    endtask

    task automatic t_mode0();
        int n;
        gate = 1'b1;
        do_load(3'd0, 1'b0, 16'd5);
        run_len(1'b0, n);
        chk("R2 low length", n, 5);
        stays_high("R2 stays high", 20);
        // R8 gate pause
        do_load(3'd0, 1'b0, 16'd5);
        repeat (2) @(negedge clk);
        chk("R8 count before pause", int'(count), 3);
        gate = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 count frozen", int'(count), 3);
        chk("R8 out frozen", int'(out), 0);
        gate = 1'b1;
        run_len(1'b0, n);
        chk("R8 remaining low", n, 3);
    endtask

    task automatic t_mode1();
        int n;
        gate = 1'b0;
        do_load(3'd1, 1'b0, 16'd3);
        chk("R3 high after load", int'(out), 1);
        repeat (5) @(negedge clk);
        chk("R3 no start without edge", int'(out), 1);
        gate = 1'b1;
        @(negedge clk);
        run_len(1'b0, n);
        chk("R3 pulse length", n, 3);
        stays_high("R3 back high", 10);
    endtask

    task automatic t_mode2();
        int n;
        gate = 1'b1;
        do_load(3'd2, 1'b0, 16'd4);
        run_len(1'b1, n); chk("R4 first high", n, 4);
        run_len(1'b0, n); chk("R4 low width", n, 1);
        run_len(1'b1, n); chk("R4 later high", n, 3);
        run_len(1'b0, n); chk("R4 low width 2", n, 1);
        gate = 1'b0;
        @(negedge clk);
        chk("R9 rate forced high", int'(out), 1);
        chk("R9 rate reloaded", int'(count), 4);
        stays_high("R9 rate held high", 3);
        gate = 1'b1;
        run_len(1'b1, n); chk("R9 rate restart high", n, 4);
    endtask

    task automatic t_mode3();
        int n;
        gate = 1'b1;
        do_load(3'd3, 1'b0, 16'd5);
        run_len(1'b1, n); chk("R5 odd high", n, 3);
        run_len(1'b0, n); chk("R5 odd low", n, 2);
        run_len(1'b1, n); chk("R5 odd high 2", n, 3);
        run_len(1'b0, n); chk("R5 odd low 2", n, 2);
        do_load(3'd3, 1'b0, 16'd6);
        run_len(1'b1, n); chk("R5 even high", n, 3);
        chk("R5 even low start", int'(out), 0);
        gate = 1'b0;
        @(negedge clk);
        chk("R9 square forced high", int'(out), 1);
        gate = 1'b1;
        run_len(1'b1, n); chk("R9 square restart high", n, 3);
        run_len(1'b0, n); chk("R5 even low", n, 3);
        // R10 decimal square wave of ten
        do_load(3'd3, 1'b1, 16'h0010);
        run_len(1'b1, n); chk("R10 bcd square high", n, 5);
        run_len(1'b0, n); chk("R10 bcd square low", n, 5);
    endtask

    task automatic t_mode4();
        int n;
        gate = 1'b0;
        do_load(3'd4, 1'b0, 16'd4);
        repeat (5) @(negedge clk);
        chk("R8 strobe held count", int'(count), 4);
        chk("R8 strobe held out", int'(out), 1);
        gate = 1'b1;
        run_len(1'b1, n); chk("R6 delay", n, 4);
        run_len(1'b0, n); chk("R6 pulse width", n, 1);
        stays_high("R6 single pulse", 20);
    endtask

    task automatic t_mode5();
        int n;
        gate = 1'b0;
        @(negedge clk);
        do_load(3'd5, 1'b0, 16'd3);
        repeat (4) @(negedge clk);
        chk("R7 idle out", int'(out), 1);
        chk("R7 idle count", int'(count), 3);
        gate = 1'b1;
        @(negedge clk);
        run_len(1'b1, n); chk("R7 delay", n, 3);
        run_len(1'b0, n); chk("R7 pulse width", n, 1);
        stays_high("R7 single pulse", 20);
    endtask

    task automatic t_bcd();
        int n;
        gate = 1'b1;
        do_load(3'd0, 1'b1, 16'h1000);
        chk("R10 loaded", int'(count), 16'h1000);
        @(negedge clk);
        chk("R10 borrow chain", int'(count), 16'h0999);
        do_load(3'd0, 1'b1, 16'h0010);
        @(negedge clk);
        chk("R10 low digit borrow", int'(count), 16'h0009);
        do_load(3'd0, 1'b1, 16'h0000);
        run_len(1'b0, n);
        chk("R11 bcd zero", n, 10000);
        do_load(3'd0, 1'b0, 16'h0000);
        run_len(1'b0, n);
        chk("R11 binary zero", n, 65536);
    endtask

    task automatic t_alias();
        int n;
        gate = 1'b1;
        do_load(3'd6, 1'b0, 16'd3);
        run_len(1'b1, n); chk("R12 code6 high", n, 3);
        run_len(1'b0, n); chk("R12 code6 low", n, 1);
        do_load(3'd7, 1'b0, 16'd4);
        run_len(1'b1, n); chk("R12 code7 high", n, 2);
        run_len(1'b0, n); chk("R12 code7 low", n, 2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_mode0();
        t_mode1();
        t_mode2();
        t_mode3();
        t_mode4();
        t_mode5();
        t_bcd();
        t_alias();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule